// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses the clock that feeds a small controller core: either an on-chip oscillator or an external resonator. After reset the core runs from the internal oscillator. Firmware writes an 8-bit configuration value. Writing a 1 into the source-select field starts a one-way move to the external source. The core clock is gated while the resonator starts. When the resonator reports that it is stable, the core clock comes back from the external source. The CPU stays held for one of two resume delays, and then it is released.

Once the block is in external mode it stays there. A later write that clears the select field does not change the source. The stored select value is read again only when a suspend wake-up occurs, and at that point it decides which source to use. The block also drives the clock-output pin. In internal mode it reports the level of the resonator input pin as a plain input bit, and it gates the enable for precise tuning of the internal oscillator. Delays are counted in microsecond ticks supplied by the caller.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset the block is in internal mode with cpu_run=1, clk_sel=0, osc_ext_en=0, osc_int_en=1, core_clk_en=1 and clkout_oe=1.
- R2: In internal mode, a write with bit 0 set moves the block to the starting state at that clock edge. In the starting state cpu_run=0, core_clk_en=0, osc_int_en=0, osc_ext_en=1 and clk_sel=0. The block stays in that state while ext_stable is low.
- R3: When ext_stable is sampled high in the starting state, the next state has clk_sel=1 and core_clk_en=1, with cpu_run still 0.
- R4: cpu_run rises at the edge that samples the Nth us_tick after R3. N is SHORT_US when bit 7 was 0 at the R3 edge, and LONG_US when it was 1.
- R5: While in an external state, writing bit 0 = 0 leaves the clock source and the run state unchanged.
- R6: On suspend_wake the stored bit 0 chooses the source. With bit 0 = 0 the block returns to internal mode at that edge. With bit 0 = 1 it re-enters the starting state of R2.
- R7: In internal mode with bit 1 = 0, clkout_lvl follows int_clk_lvl. With bit 1 = 1, clkout_lvl is 1. In every external state clkout_oe=0 and clkout_lvl=0, whatever value bit 1 has.
- R8: gpio_xin equals xin_pin in internal mode and is 0 in every external state.
- R9: tune_en equals bit 2 in internal mode and is 0 in every external state.
- R10: In internal mode, a write with bit 0 = 0 keeps the block in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Write data. Bit 0 selects external, bit 1 disables the clock output, bit 2 enables tuning, bit 7 selects the long delay |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| ext_stable | input | 1 | External oscillator is stable |
| suspend_wake | input | 1 | Wake-up from suspend event |
| xin_pin | input | 1 | Level of the resonator input pin |
| int_clk_lvl | input | 1 | Current level of the internal oscillator |
| cpu_run | output | 1 | CPU release |
| clk_sel | output | 1 | 1 selects the external clock for the core |
| osc_ext_en | output | 1 | External oscillator enable |
| osc_int_en | output | 1 | Internal oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| clkout_oe | output | 1 | Clock-output pin drive enable |
| clkout_lvl | output | 1 | Clock-output pin level |
| gpio_xin | output | 1 | Resonator input pin seen as an input bit |
| tune_en | output | 1 | Precise tuning enable for the internal oscillator |

## Verification
The switch is first run with bit 7 clear. us_tick pulses only every other cycle, so the test can tell a delay counted in ticks from one counted in clock cycles. It then runs with bit 7 set and an irregular tick pattern, which separates the two delay lengths. Clearing writes are sent both while the block waits for stability and while it runs from the external clock, and the checks confirm the switch is one-way. Suspend wake-ups are applied once with bit 0 clear and once with it set, which shows that the stored bit, and not the mode the block is in, picks the source.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    CS_INT    = 2'd0,
    CS_WAIT   = 2'd1,
    CS_RESUME = 2'd2,
    CS_EXT    = 2'd3
  } clksw_state_e;

  localparam int CFG_W      = 8;
  localparam int F_EXT_SEL  = 0;
  localparam int F_OUT_OFF  = 1;
  localparam int F_TUNE     = 2;
  localparam int F_SLOW_RES = 7;

  function automatic int unsigned resume_limit(input logic slow,
                                               input int unsigned short_us,
                                               input int unsigned long_us);
    return slow ? long_us : short_us;
  endfunction

  function automatic logic is_external(input clksw_state_e s);
    return s != CS_INT;
  endfunction

endpackage

// File: rtl/clksw_cfg_reg.sv
module clksw_cfg_reg
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end

endmodule

// File: rtl/clksw_delay_timer.sv
module clksw_delay_timer
  import clksw_pkg::*;
#(
  parameter int unsigned SHORT_US = 128,
  parameter int unsigned LONG_US  = 4000,
  parameter int          CNT_W    = $clog2(LONG_US + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic slow_sel,
  input  logic run,
  input  logic tick,
  output logic done
);

  logic             slow_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_m1;

  assign limit_m1 = CNT_W'(resume_limit(slow_q, SHORT_US, LONG_US) - 1);
  assign done     = run && tick && (cnt_q == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      slow_q <= slow_sel;
      cnt_q  <= '0;
    end else if (run && tick && !done) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit_m1));

endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic cfg_ext,
  input  logic ext_stable,
  input  logic suspend_wake,
  input  logic timer_done,
  output logic timer_load,
  output logic timer_run,
  output logic int_mode,
  output logic cpu_run,
  output logic clk_sel,
  output logic osc_ext_en,
  output logic osc_int_en,
  output logic core_clk_en
);

  clksw_state_e state_q, state_d;

  assign timer_load = (state_q == CS_WAIT) && ext_stable && !suspend_wake;
  assign timer_run  = (state_q == CS_RESUME);

  always_comb begin
    state_d = state_q;
    if (suspend_wake) begin
      state_d = cfg_ext ? CS_WAIT : CS_INT;
    end else begin
      unique case (state_q)
        CS_INT:    if (ext_req)    state_d = CS_WAIT;
        CS_WAIT:   if (ext_stable) state_d = CS_RESUME;
        CS_RESUME: if (timer_done) state_d = CS_EXT;
        CS_EXT:    state_d = CS_EXT;
        default:   state_d = CS_INT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_INT;
    else        state_q <= state_d;
  end

  assign int_mode    = !is_external(state_q);
  assign cpu_run     = (state_q == CS_INT) || (state_q == CS_EXT);
  assign clk_sel     = (state_q == CS_RESUME) || (state_q == CS_EXT);
  assign osc_ext_en  = is_external(state_q);
  assign osc_int_en  = (state_q == CS_INT);
  assign core_clk_en = (state_q != CS_WAIT);

  assert_hold_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_WAIT && !ext_stable && !suspend_wake) |=> (state_q == CS_WAIT));

  assert_one_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel && !suspend_wake) |=> clk_sel);

  assert_wake_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_wake && !cfg_ext) |=> (osc_int_en && cpu_run));

  assert_wake_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_wake && cfg_ext) |=> (!core_clk_en && osc_ext_en));

endmodule

// File: rtl/clksw_pin_mux.sv
module clksw_pin_mux (
  input  logic int_mode,
  input  logic out_off,
  input  logic tune_bit,
  input  logic xin_pin,
  input  logic int_clk_lvl,
  output logic clkout_oe,
  output logic clkout_lvl,
  output logic gpio_xin,
  output logic tune_en
);

  always_comb begin
    clkout_oe  = int_mode;
    clkout_lvl = 1'b0;
    if (int_mode) clkout_lvl = out_off ? 1'b1 : int_clk_lvl;
    gpio_xin   = int_mode & xin_pin;
    tune_en    = int_mode & tune_bit;
  end

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned SHORT_US = 128,
  parameter int unsigned LONG_US  = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  input  logic       us_tick,
  input  logic       ext_stable,
  input  logic       suspend_wake,
  input  logic       xin_pin,
  input  logic       int_clk_lvl,
  output logic       cpu_run,
  output logic       clk_sel,
  output logic       osc_ext_en,
  output logic       osc_int_en,
  output logic       core_clk_en,
  output logic       clkout_oe,
  output logic       clkout_lvl,
  output logic       gpio_xin,
  output logic       tune_en
);

  localparam int CNT_W = $clog2(LONG_US + 1);

  logic [CFG_W-1:0] cfg_q;
  logic ext_req, timer_load, timer_run, timer_done, int_mode;

  assign ext_req = cfg_wr_en && cfg_wr_data[F_EXT_SEL];

  clksw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .cfg_q(cfg_q)
  );

  clksw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .cfg_ext(cfg_q[F_EXT_SEL]),
    .ext_stable(ext_stable), .suspend_wake(suspend_wake), .timer_done(timer_done),
    .timer_load(timer_load), .timer_run(timer_run), .int_mode(int_mode),
    .cpu_run(cpu_run), .clk_sel(clk_sel), .osc_ext_en(osc_ext_en),
    .osc_int_en(osc_int_en), .core_clk_en(core_clk_en)
  );

  clksw_delay_timer #(.SHORT_US(SHORT_US), .LONG_US(LONG_US), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .slow_sel(cfg_q[F_SLOW_RES]),
    .run(timer_run), .tick(us_tick), .done(timer_done)
  );

  clksw_pin_mux u_pins (
    .int_mode(int_mode), .out_off(cfg_q[F_OUT_OFF]), .tune_bit(cfg_q[F_TUNE]),
    .xin_pin(xin_pin), .int_clk_lvl(int_clk_lvl), .clkout_oe(clkout_oe),
    .clkout_lvl(clkout_lvl), .gpio_xin(gpio_xin), .tune_en(tune_en)
  );

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_run) && clk_sel) |-> $past(timer_done));

  assert_gated_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> !cpu_run);

  assert_pin_off_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_ext_en |-> (!clkout_oe && !clkout_lvl));

  assert_gpio_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_int_en |-> !gpio_xin);

  assert_tune_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> !tune_en);

endmodule

// File: tb/tb_clksw_ctrl.sv
module tb_clksw_ctrl;

  localparam int unsigned SHORT = 4;
  localparam int unsigned LONG  = 9;
  typedef enum int {M_INT, M_WAIT, M_RES, M_RUN} mode_e;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic us_tick = 1'b0, ext_stable = 1'b0, suspend_wake = 1'b0;
  logic xin_pin = 1'b0, int_clk_lvl = 1'b0;
  logic cpu_run, clk_sel, osc_ext_en, osc_int_en, core_clk_en;
  logic clkout_oe, clkout_lvl, gpio_xin, tune_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] cfg_m = '0;
  logic [8:0] q_exp[$];
  string q_tag[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clksw_ctrl #(.SHORT_US(SHORT), .LONG_US(LONG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .us_tick(us_tick), .ext_stable(ext_stable), .suspend_wake(suspend_wake),
    .xin_pin(xin_pin), .int_clk_lvl(int_clk_lvl), .cpu_run(cpu_run),
    .clk_sel(clk_sel), .osc_ext_en(osc_ext_en), .osc_int_en(osc_int_en),
    .core_clk_en(core_clk_en), .clkout_oe(clkout_oe), .clkout_lvl(clkout_lvl),
    .gpio_xin(gpio_xin), .tune_en(tune_en)
  );

  // expected {cpu_run, clk_sel, osc_ext_en, osc_int_en, core_clk_en, clkout_oe, clkout_lvl, gpio_xin, tune_en}
  function automatic logic [8:0] model(mode_e m, logic [7:0] c, logic x, logic ick);
    case (m)
      M_INT:   return {5'b10011, 1'b1, (c[1] | ick), x, c[2]};
      M_WAIT:  return 9'b001000000;
      M_RES:   return 9'b011010000;
      default: return 9'b111010000;
    endcase
  endfunction

  task automatic drive(input logic wr, input logic [7:0] d, input logic st,
                       input logic wk, input logic tk);
    @(negedge clk);
    cfg_wr_en = wr; cfg_wr_data = d; ext_stable = st; suspend_wake = wk; us_tick = tk;
    if (wr) cfg_m = d;
  endtask

  task automatic push(input mode_e m, input string tag);
    q_exp.push_back(model(m, cfg_m, xin_pin, int_clk_lvl));
    q_tag.push_back(tag);
  endtask

  // monitor: scoreboard pop after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [8:0] e;
        logic [8:0] a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {cpu_run, clk_sel, osc_ext_en, osc_int_en, core_clk_en,
             clkout_oe, clkout_lvl, gpio_xin, tune_en};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 8'h00, 0, 0, 0); xin_pin = 1; int_clk_lvl = 0;
    push(M_INT, "R1 reset state, R8 pin visible");
    drive(0, 8'h00, 0, 0, 0); int_clk_lvl = 1;
    push(M_INT, "R7 internal clock on pin");
    drive(1, 8'h02, 0, 0, 0); int_clk_lvl = 0;
    push(M_INT, "R7 pin held high, R10 stays internal");
    drive(1, 8'h04, 0, 0, 0); xin_pin = 0;
    push(M_INT, "R9 tune in internal, R10 stays internal");
    drive(1, 8'h05, 0, 0, 0);
    push(M_WAIT, "R2 enter gated start, R9 tune off");
    for (int k = 0; k < 3; k++) begin
      drive(0, 8'h00, 0, 0, 1); xin_pin = ~xin_pin; int_clk_lvl = ~int_clk_lvl;
      push(M_WAIT, "R2 held gated, R8 pin hidden");
    end
    drive(1, 8'h00, 0, 0, 0);
    push(M_WAIT, "R5 clear during start ignored");
    drive(0, 8'h00, 1, 0, 0);
    push(M_RES, "R3 stable resumes clock");
    ticks = 0;
    for (int k = 0; k < 40 && ticks < int'(SHORT); k++) begin
      drive(0, 8'h00, 1, 0, logic'(k % 2));
      if (k % 2 == 1) ticks++;
      push((ticks == int'(SHORT)) ? M_RUN : M_RES, "R4 short delay");
    end
    drive(1, 8'h02, 1, 0, 0);
    push(M_RUN, "R5 clear in external ignored, R7 bit1 no effect");
    drive(0, 8'h00, 0, 1, 0);
    push(M_INT, "R6 wake with bit0 clear");
    drive(1, 8'h81, 0, 0, 0);
    push(M_WAIT, "R2 second switch");
    drive(0, 8'h00, 1, 0, 0);
    push(M_RES, "R3 stable second switch");
    ticks = 0;
    for (int k = 0; k < 60 && ticks < int'(LONG); k++) begin
      drive(0, 8'h00, 1, 0, logic'(k % 3 != 1));
      if (k % 3 != 1) ticks++;
      push((ticks == int'(LONG)) ? M_RUN : M_RES, "R4 long delay");
    end
    drive(0, 8'h00, 0, 1, 0);
    push(M_WAIT, "R6 wake with bit0 set");
    drive(0, 8'h00, 1, 0, 0);
    push(M_RES, "R3 stable after wake");
    ticks = 0;
    for (int k = 0; k < 30 && ticks < int'(LONG); k++) begin
      drive(0, 8'h00, 1, 0, 1);
      ticks++;
      push((ticks == int'(LONG)) ? M_RUN : M_RES, "R4 long delay after wake");
    end
    drive(0, 8'h00, 0, 0, 0);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule